// File: doc/BRIEF.md
# Packed Double-Precision Magnitude Comparator

This unit orders the magnitudes of eight double-precision values held side by side in each of two 512-bit operand vectors. For each 64-bit lane it raises one bit of an 8-bit result mask when the magnitude of the left operand is below the magnitude of the right operand. A build-time parameter can relax this to below-or-equal. It does no floating-point arithmetic. Each lane copies the left operand's sign bit into the right operand through a generic three-input bitwise function, then runs one unsigned integer compare on the two raw 64-bit patterns. Because both patterns then carry the same sign, the compare reduces to an ordering of the exponent and fraction fields. For any non-NaN double, that ordering matches the ordering of the magnitudes.

A caller presents both vectors with `in_valid`. With the default output register, the mask and `out_valid` appear one clock later, and the mask keeps its value between accepted beats. The asynchronous active-low reset asserts at once but releases through a two-stage synchronizer. NaN lanes give an unspecified bit.

Top module: `dmag_cmp`

## Requirements
- R1: Lane k occupies bits [64k+63:64k] of each operand vector, and mask bit k depends only on lane k of the two vectors.
- R2: With the default predicate, for non-NaN lanes, mask bit k is 1 exactly when |left| < |right| (bit 63 is the sign, bits 62:52 the exponent, bits 51:0 the fraction).
- R3: The sign bits of either operand have no effect on the lane result.
- R4: +0 and -0 have equal magnitude. Any pairing of them gives 0 under the strict predicate and 1 under the inclusive one.
- R5: An infinity (exponent all ones, fraction zero) orders above every finite magnitude. Two infinities have equal magnitude.
- R6: Subnormals (exponent zero, fraction nonzero) order correctly among themselves, above zero and below the smallest normal.
- R7: With the inclusive predicate selected, mask bit k is 1 exactly when |left| <= |right|.
- R8: With the output register enabled, `out_valid` is 1 in the cycle after each clock edge that samples `in_valid` high and 0 after each edge that samples it low. The mask for that beat appears together with `out_valid`.
- R9: An edge that samples `in_valid` low leaves `lt_mask` unchanged, whatever the operands are.
- R10: While `rst_n` is low, `out_valid` and `lt_mask` are 0. `out_valid` stays 0 until a beat is accepted after the release has passed through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand vectors are valid this cycle |
| opa | input | 512 | Left operands, eight 64-bit lanes |
| opb | input | 512 | Right operands, eight 64-bit lanes |
| out_valid | output | 1 | Mask is the result of an accepted beat |
| lt_mask | output | 8 | One magnitude-compare result per lane |

## Verification
The hardest cases to reach are lanes whose raw patterns differ only in the sign bit, or only in the lowest fraction bit near an exponent boundary. Uniform random 64-bit values almost never produce them. The stimulus therefore draws each lane from weighted classes: zeros, subnormals, infinities, normals, and mirrored copies of the partner with the sign flipped or the last bit nudged. It also adds directed vectors that walk one true lane across the mask and that try all four sign pairings on the same magnitudes. Two instances, one per predicate, see the same beats, so equal-magnitude lanes have to split the two masks.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

  typedef enum logic { PRED_LT = 1'b0, PRED_LE = 1'b1 } pred_e;

  // three-input bitwise function: out = sel ? x : y, index {sel,x,y}
  localparam logic [7:0] TT_SPLICE = 8'hCA;

  // selector that keeps the right operand's magnitude field and
  // takes the sign position from the left operand
  function automatic logic [63:0] keep_mag_sel(input int unsigned w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++)
      if (i < int'(w) - 1) r[i] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/dmag_tlog.sv
module dmag_tlog #(
  parameter int unsigned W  = 64,
  parameter logic [7:0]  TT = dmag_pkg::TT_SPLICE
) (
  input  logic [W-1:0] sel,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] f
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] idx;
    assign idx  = {sel[i], x[i], y[i]};
    assign f[i] = TT[idx];
  end

endmodule

// File: rtl/dmag_lane.sv
module dmag_lane #(
  parameter int unsigned    W    = 64,
  parameter dmag_pkg::pred_e PRED = dmag_pkg::PRED_LT
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);

  localparam logic [63:0] SEL_FULL = dmag_pkg::keep_mag_sel(W);
  localparam logic [W-1:0] SEL     = SEL_FULL[W-1:0];

  logic [W-1:0] b_spliced;

  dmag_tlog #(.W(W), .TT(dmag_pkg::TT_SPLICE)) u_splice (
    .sel (SEL),
    .x   (b),
    .y   (a),
    .f   (b_spliced)
  );

  if (PRED == dmag_pkg::PRED_LE) begin : g_le
    assign hit = (a <= b_spliced);
  end else begin : g_lt
    assign hit = (a < b_spliced);
  end

endmodule

// File: rtl/dmag_rst_sync.sv
module dmag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/dmag_out_stage.sv
module dmag_out_stage #(
  parameter int unsigned LANES   = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LANES-1:0] mask_d,
  output logic             out_valid,
  output logic [LANES-1:0] mask_q
);

  if (OUT_REG) begin : g_reg
    logic             vld_q, vld_n;
    logic [LANES-1:0] msk_q, msk_n;
    logic             load_en;

    always_comb begin
      load_en = in_valid;
      vld_n   = in_valid;
      msk_n   = msk_q;
      if (load_en) msk_n = mask_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        msk_q <= '0;
      end else begin
        vld_q <= vld_n;
        msk_q <= msk_n;
      end
    end

    assign out_valid = vld_q;
    assign mask_q    = msk_q;
  end else begin : g_comb
    assign out_valid = in_valid & rst_n;
    assign mask_q    = mask_d;
  end

endmodule

// File: rtl/dmag_cmp.sv
module dmag_cmp #(
  parameter int unsigned     LANES   = 8,
  parameter int unsigned     LANE_W  = 64,
  parameter bit              OUT_REG = 1'b1,
  parameter dmag_pkg::pred_e PRED    = dmag_pkg::PRED_LT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] opa,
  input  logic [LANES*LANE_W-1:0] opb,
  output logic                    out_valid,
  output logic [LANES-1:0]        lt_mask
);

  localparam int unsigned VEC_W = LANES * LANE_W;

  logic             rst_int_n;
  logic [LANES-1:0] lane_hit;

  dmag_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dmag_lane #(.W(LANE_W), .PRED(PRED)) u_lane (
      .a   (opa[k*LANE_W +: LANE_W]),
      .b   (opb[k*LANE_W +: LANE_W]),
      .hit (lane_hit[k])
    );
  end

  dmag_out_stage #(.LANES(LANES), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (in_valid),
    .mask_d    (lane_hit),
    .out_valid (out_valid),
    .mask_q    (lt_mask)
  );

  if (VEC_W == 0) begin : g_never
    initial $display("empty vector");
  end

endmodule

// File: rtl/dmag_cmp_chk.sv
module dmag_cmp_chk #(
  parameter int unsigned     LANES   = 8,
  parameter int unsigned     LANE_W  = 64,
  parameter bit              OUT_REG = 1'b1,
  parameter dmag_pkg::pred_e PRED    = dmag_pkg::PRED_LT
) (
  input logic                    clk,
  input logic                    rst_int_n,
  input logic                    in_valid,
  input logic [LANES*LANE_W-1:0] opa,
  input logic [LANES*LANE_W-1:0] opb,
  input logic                    out_valid,
  input logic [LANES-1:0]        lt_mask
);

  localparam int unsigned MW = LANE_W - 1;

  logic [LANES-1:0] mag_ref;
  logic [LANES-1:0] both_zero;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [MW-1:0] ma, mb;
      ma = opa[l*LANE_W +: MW];
      mb = opb[l*LANE_W +: MW];
      mag_ref[l]   = (PRED == dmag_pkg::PRED_LE) ? (ma <= mb) : (ma < mb);
      both_zero[l] = (ma == '0) && (mb == '0);
    end
  end

  // R10
  always @(posedge clk) begin
    if (!rst_int_n) begin
      rst_clear_chk: assert (!out_valid && lt_mask == '0);
    end
  end

  if (OUT_REG) begin : g_reg
    // R8
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      in_valid |=> out_valid);
    // R8
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      !in_valid |=> !out_valid);
    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      !in_valid |=> $stable(lt_mask));
    // R2
    mag_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      in_valid |=> (lt_mask == $past(mag_ref)));
    for (genvar l = 0; l < LANES; l++) begin : g_z
      // R4
      zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (in_valid && both_zero[l]) |=> (lt_mask[l] == (PRED == dmag_pkg::PRED_LE)));
    end
  end else begin : g_comb
    // R2
    mag_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      in_valid |-> (lt_mask == mag_ref));
    // R8
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      in_valid |-> out_valid);
  end

endmodule

bind dmag_cmp dmag_cmp_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .OUT_REG(OUT_REG), .PRED(PRED)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .in_valid  (in_valid),
  .opa       (opa),
  .opb       (opb),
  .out_valid (out_valid),
  .lt_mask   (lt_mask)
);

// File: tb/test_dmag_cmp.sv
`timescale 1ns/1ps
module test_dmag_cmp;

  localparam int L = 8;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] MAXF   = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN   = 64'h0010_0000_0000_0000;
  localparam logic [63:0] MAXS   = 64'h000F_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NZERO  = 64'h8000_0000_0000_0000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [L*64-1:0] opa = '0, opb = '0;
  logic           ov_lt, ov_le;
  logic [L-1:0]   m_lt, m_le;

  int checks = 0;
  int fails  = 0;
  logic [L-1:0] q_lt[$];
  logic [L-1:0] q_le[$];
  string        q_tag[$];
  logic [63:0]  la[L];
  logic [63:0]  lb[L];
  logic [L-1:0] last_lt;

  always #4 clk = ~clk;

  dmag_cmp i_dmag_cmp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .out_valid(ov_lt), .lt_mask(m_lt));

  dmag_cmp #(.PRED(dmag_pkg::PRED_LE)) i_dmag_cmp_le (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .out_valid(ov_le), .lt_mask(m_le));

  function automatic real absr(input logic [63:0] v);
    real r;
    r = $bitstoreal(v);
    return (r < 0.0) ? -r : r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag);
    logic [L-1:0] elt, ele;
    @(negedge clk);
    for (int k = 0; k < L; k++) begin
      opa[k*64 +: 64] = la[k];
      opb[k*64 +: 64] = lb[k];
      elt[k] = absr(la[k]) <  absr(lb[k]);
      ele[k] = absr(la[k]) <= absr(lb[k]);
    end
    in_valid = 1'b1;
    q_lt.push_back(elt);
    q_le.push_back(ele);
    q_tag.push_back(tag);
    last_lt = elt;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
             $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      opb = ~opa;
    end
  endtask

  function automatic logic [63:0] rand_dbl();
    logic [63:0] v;
    int c;
    c = $urandom % 6;
    v = {$urandom, $urandom};
    case (c)
      0: v[62:0] = '0;
      1: v[62:52] = '0;
      2: v[62:0] = P_INF[62:0];
      default: if (v[62:52] == 11'h7FF) v[62:52] = 11'h7FE;
    endcase
    return v;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && ov_lt) begin
      if (q_lt.size() == 0) begin
        check("R8 unexpected out_valid", 64'(ov_lt), 64'd0);
      end else begin
        logic [L-1:0] elt, ele;
        string tg;
        elt = q_lt.pop_front();
        ele = q_le.pop_front();
        tg  = q_tag.pop_front();
        check({tg, " strict mask"}, 64'(m_lt), 64'(elt));
        check({tg, " R7 inclusive mask"}, 64'(m_le), 64'(ele));
        check("R8 valid pair", 64'(ov_le), 64'd1);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    last_lt = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid in reset", 64'(ov_lt), 64'd0);
    check("R10 mask in reset", 64'(m_lt), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 out_valid after release", 64'(ov_lt), 64'd0);

    // R4 zeros and tiny values
    la = '{64'd0, NZERO, 64'd0, NZERO, 64'd0, 64'd1, NZERO, 64'd1 | NZERO};
    lb = '{64'd0, 64'd0, NZERO, NZERO, 64'd1 | NZERO, NZERO, 64'd1, 64'd1};
    send("R4 signed zeros");
    // R5 infinities
    la = '{P_INF, MAXF, P_INF, P_INF | NZERO, ONE, MAXF | NZERO, P_INF, 64'd0};
    lb = '{MAXF, P_INF | NZERO, P_INF, P_INF, P_INF | NZERO, P_INF, P_INF | NZERO, P_INF};
    send("R5 infinities");
    // R6 subnormals
    la = '{64'd1, MAXS, MAXS, MINN, 64'd2, MAXS | NZERO, 64'd3, MAXS - 1};
    lb = '{64'd2, MINN, MAXS - 1, MAXS | NZERO, 64'd1, MINN | NZERO, 64'd0, MAXS};
    send("R6 subnormals");
    // R1 single true lane walking across the mask
    for (int k = 0; k < L; k++) begin
      for (int j = 0; j < L; j++) begin
        la[j] = ONE;
        lb[j] = (j == k) ? ONE + 1 : ONE;
      end
      send("R1 lane walk");
    end
    // R3 sign pairings on fixed magnitudes
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < L; j++) begin
        la[j] = {s[1] ^ j[0], 63'(ONE[62:0] + 64'(j))};
        lb[j] = {s[0],        63'(ONE[62:0] + 64'(3))};
      end
      send("R3 sign pairing");
    end
    idle(2);
    // R9 hold across idle cycles
    la = '{ONE, 64'd0, MAXF, 64'd1, MINN, ONE, 64'd0, P_INF};
    lb = '{MAXF, ONE, ONE, 64'd2, MAXS, P_INF, NZERO, MAXF};
    send("R9 setup");
    idle(1);
    for (int i = 0; i < 3; i++) begin
      idle(1);
      check("R9 held mask", 64'(m_lt), 64'(last_lt));
      check("R8 valid low when idle", 64'(ov_lt), 64'd0);
    end
    // R2 random non-NaN, with mirrored partners
    for (int n = 0; n < 400; n++) begin
      for (int j = 0; j < L; j++) begin
        la[j] = rand_dbl();
        case ($urandom % 4)
          0: lb[j] = la[j] ^ NZERO;
          1: lb[j] = (la[j][62:0] == P_INF[62:0] || la[j][62:0] == '0) ? la[j] : la[j] + 1;
          default: lb[j] = rand_dbl();
        endcase
      end
      send("R2 random");
      if (n % 37 == 0) idle(1);
    end
    idle(3);
    check("R8 scoreboard drained", 64'(q_lt.size()), 64'd0);
    // R10 reset mid-run after a beat
    la = '{ONE, ONE, ONE, ONE, ONE, ONE, ONE, ONE};
    lb = '{MAXF, MAXF, MAXF, MAXF, MAXF, MAXF, MAXF, MAXF};
    send("R10 pre-reset");
    idle(1);
    #1 rst_n = 1'b0;
    #1;
    check("R10 async clear valid", 64'(ov_lt), 64'd0);
    check("R10 async clear mask", 64'(m_lt), 64'd0);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    check("R10 valid after re-release", 64'(ov_lt), 64'd0);
    finish_run();
  end

endmodule